// File: doc/BRIEF.md
# Bootstrap SRAM-to-instruction-memory loader

This block holds a small always-powered bootstrap store of 256 dwords (1024 bytes) and copies a chosen part of it into an instruction memory through a simple write port. The host fills the store one dword at a time over a register bus. It then sets a source byte offset inside the store, a destination byte address, and a length in dwords. A write that sets the go bit in the control register starts the copy. The go bit reads back as 1 while the copy runs and drops to 0 when it ends, so the host can poll it. A done flag in the status register gives the same information.

The control register also has an arm bit. While it is set, every pulse on the power-up event input replays the copy with the configured parameters, with no host action. The store has no reset and no clear path, so the program it holds lasts through the sleep periods between power-up events.

Bus reads return data on the cycle after the read strobe. The source, destination and count registers can be written at any time. The engine takes its own copy of them at launch.

Top module: `boot_loader`

## Requirements
- R1: After reset the control register and the status register read 0, and no instruction-memory write is issued.
- R2: A host write at bus offset 0x400 + 4*i stores dword i of the bootstrap store (0 <= i < 256). A read at the same offset returns it one cycle after the read strobe. The other registers sit at offsets 0x000 (control), 0x004 (source byte offset), 0x008 (destination byte address), 0x00C (dword count) and 0x010 (status).
- R3: Writing control with bit 31 set while idle launches a copy. Control bit 31 reads 1 while the copy is active and 0 once it has finished.
- R4: Write k of a copy (counting from 0) goes to destination + 4*k and carries store dword (source/4 + k).
- R5: With imem_ready held high, the engine moves one dword per clock. While imem_wr is high and imem_ready is low, address and data hold steady.
- R6: Status bit 0 becomes 1 on the same edge at which control bit 31 returns to 0. Every launch clears it.
- R7: A launch with a count of 0 issues no write and sets status bit 0 on the next edge.
- R8: Host writes to the bootstrap store during an active copy are dropped: neither the copied data nor a later readback changes.
- R9: Setting control bit 31 again during an active copy has no effect on the number of words written or on their contents.
- R10: Control bit 30 is the arm bit. A pulse on pwr_up launches a copy only when the arm bit is set and no copy is active. This repeats for every such pulse.
- R11: The bootstrap store contents survive copies and power-up events unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset of the registers; the store is not reset |
| bus_wr | input | 1 | Register bus write strobe |
| bus_rd | input | 1 | Register bus read strobe |
| bus_addr | input | 12 | Byte offset of the access within the block |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after bus_rd |
| pwr_up | input | 1 | One-cycle power-up event |
| imem_wr | output | 1 | Instruction memory write request |
| imem_addr | output | 32 | Instruction memory byte address |
| imem_wdata | output | 32 | Instruction memory write data |
| imem_ready | input | 1 | Instruction memory accepts the write this cycle |

## Verification
A wrong remaining-word count or a wrong source index shows up at the instruction-memory port in the cycle it is wrong: an extra or missing write, or a data word from the wrong store entry. The bench records every accepted write, so either error appears as soon as the copy ends. A mistake in the done or go handshake shows on the first status or control read after a launch or a completion. A store write that leaks in during a copy shows both in the copied data and in a store readback.

// File: rtl/bl_pkg.sv
package bl_pkg;
    localparam int DW = 32;
    localparam logic [7:0] OFF_CTRL = 8'h00;
    localparam logic [7:0] OFF_SRC  = 8'h04;
    localparam logic [7:0] OFF_DST  = 8'h08;
    localparam logic [7:0] OFF_CNT  = 8'h0C;
    localparam logic [7:0] OFF_STAT = 8'h10;
    localparam int GO_BIT   = 31;
    localparam int ARM_BIT  = 30;
    localparam int DONE_BIT = 0;
endpackage

// File: rtl/bl_store.sv
module bl_store #(
    parameter int WORDS = 256,
    parameter int IDX_W = $clog2(WORDS)
) (
    input  logic             clk,
    input  logic             we,
    input  logic [IDX_W-1:0] waddr,
    input  logic [31:0]      wdata,
    input  logic [IDX_W-1:0] raddr_host,
    output logic [31:0]      rdata_host,
    input  logic [IDX_W-1:0] raddr_copy,
    output logic [31:0]      rdata_copy
);
    logic [31:0] mem [WORDS];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata_host = mem[raddr_host];
    assign rdata_copy = mem[raddr_copy];
endmodule

// File: rtl/bl_copy_engine.sv
module bl_copy_engine #(
    parameter int IDX_W = 8,
    parameter int CNT_W = IDX_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             launch,
    input  logic [IDX_W-1:0] cfg_idx,
    input  logic [31:0]      cfg_dst,
    input  logic [CNT_W-1:0] cfg_cnt,
    output logic             busy,
    output logic             finish,
    output logic [IDX_W-1:0] rd_idx,
    input  logic [31:0]      rd_data,
    output logic             imem_wr,
    output logic [31:0]      imem_addr,
    output logic [31:0]      imem_wdata,
    input  logic             imem_ready
);
    typedef struct packed {
        logic             busy;
        logic [IDX_W-1:0] idx;
        logic [31:0]      dst;
        logic [CNT_W-1:0] left;
    } eng_t;

    eng_t eng_q, eng_d;

    always_comb begin
        eng_d  = eng_q;
        finish = 1'b0;
        if (!eng_q.busy) begin
            if (launch) begin
                if (cfg_cnt == '0) begin
                    finish = 1'b1;
                end else begin
                    eng_d.busy = 1'b1;
                    eng_d.idx  = cfg_idx;
                    eng_d.dst  = cfg_dst;
                    eng_d.left = cfg_cnt;
                end
            end
        end else if (imem_ready) begin
            eng_d.idx  = eng_q.idx + 1'b1;
            eng_d.dst  = eng_q.dst + 32'd4;
            eng_d.left = eng_q.left - 1'b1;
            if (eng_q.left == CNT_W'(1)) begin
                eng_d.busy = 1'b0;
                finish     = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) eng_q <= '0;
        else        eng_q <= eng_d;
    end

    assign busy       = eng_q.busy;
    assign rd_idx     = eng_q.idx;
    assign imem_wr    = eng_q.busy;
    assign imem_addr  = eng_q.dst;
    assign imem_wdata = rd_data;

    // R5: a stalled write keeps address and data
    a_r5_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
        imem_wr && !imem_ready |=> imem_wr && $stable(imem_addr) && $stable(imem_wdata));

    // R4: consecutive accepted writes step the address by one dword
    a_r4_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
        imem_wr && imem_ready && eng_q.left > CNT_W'(1) |=> imem_wr && imem_addr == $past(imem_addr) + 32'd4);

    // R3: the last accepted write ends the copy
    a_r3_last_ends: assert property (@(posedge clk) disable iff (!rst_n)
        imem_wr && imem_ready && eng_q.left == CNT_W'(1) |=> !imem_wr);
endmodule

// File: rtl/boot_loader.sv
module boot_loader
    import bl_pkg::*;
#(
    parameter int               SRAM_BYTES = 1024,
    parameter int               ADDR_W     = 12,
    parameter logic [ADDR_W-1:0] SRAM_BASE = 12'h400
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              pwr_up,
    output logic              imem_wr,
    output logic [31:0]       imem_addr,
    output logic [31:0]       imem_wdata,
    input  logic              imem_ready
);
    localparam int WORDS = SRAM_BYTES / 4;
    localparam int IDX_W = $clog2(WORDS);
    localparam int CNT_W = IDX_W + 1;
    localparam int OFS_W = IDX_W + 2;

    typedef struct packed {
        logic             arm;
        logic             done;
        logic [OFS_W-1:0] src;
        logic [31:0]      dst;
        logic [CNT_W-1:0] cnt;
        logic [31:0]      rdata;
    } regs_t;

    regs_t regs_q, regs_d;

    logic             in_sram, ctrl_wr, launch, store_we;
    logic             eng_busy, eng_finish;
    logic [IDX_W-1:0] copy_idx;
    logic [31:0]      host_word, copy_word;

    assign in_sram  = bus_addr[ADDR_W-1:OFS_W] == SRAM_BASE[ADDR_W-1:OFS_W];
    assign ctrl_wr  = bus_wr && bus_addr == ADDR_W'(OFF_CTRL);
    assign launch   = !eng_busy && ((ctrl_wr && bus_wdata[GO_BIT]) || (pwr_up && regs_q.arm));
    assign store_we = bus_wr && in_sram && !eng_busy;

    always_comb begin
        regs_d = regs_q;
        if (bus_wr) begin
            if (bus_addr == ADDR_W'(OFF_CTRL)) regs_d.arm = bus_wdata[ARM_BIT];
            if (bus_addr == ADDR_W'(OFF_SRC))  regs_d.src = bus_wdata[OFS_W-1:0];
            if (bus_addr == ADDR_W'(OFF_DST))  regs_d.dst = bus_wdata;
            if (bus_addr == ADDR_W'(OFF_CNT))  regs_d.cnt = bus_wdata[CNT_W-1:0];
        end
        if (launch)     regs_d.done = 1'b0;
        if (eng_finish) regs_d.done = 1'b1;
        if (bus_rd) begin
            regs_d.rdata = '0;
            if (in_sram) begin
                regs_d.rdata = host_word;
            end else begin
                unique case (bus_addr)
                    ADDR_W'(OFF_CTRL): begin
                        regs_d.rdata[GO_BIT]  = eng_busy;
                        regs_d.rdata[ARM_BIT] = regs_q.arm;
                    end
                    ADDR_W'(OFF_SRC):  regs_d.rdata = 32'(regs_q.src);
                    ADDR_W'(OFF_DST):  regs_d.rdata = regs_q.dst;
                    ADDR_W'(OFF_CNT):  regs_d.rdata = 32'(regs_q.cnt);
                    ADDR_W'(OFF_STAT): regs_d.rdata[DONE_BIT] = regs_q.done;
                    default:           regs_d.rdata = '0;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    assign bus_rdata = regs_q.rdata;

    bl_store #(.WORDS(WORDS), .IDX_W(IDX_W)) u_store (
        .clk        (clk),
        .we         (store_we),
        .waddr      (bus_addr[OFS_W-1:2]),
        .wdata      (bus_wdata),
        .raddr_host (bus_addr[OFS_W-1:2]),
        .rdata_host (host_word),
        .raddr_copy (copy_idx),
        .rdata_copy (copy_word)
    );

    bl_copy_engine #(.IDX_W(IDX_W), .CNT_W(CNT_W)) u_engine (
        .clk        (clk),
        .rst_n      (rst_n),
        .launch     (launch),
        .cfg_idx    (regs_q.src[OFS_W-1:2]),
        .cfg_dst    (regs_q.dst),
        .cfg_cnt    (regs_q.cnt),
        .busy       (eng_busy),
        .finish     (eng_finish),
        .rd_idx     (copy_idx),
        .rd_data    (copy_word),
        .imem_wr    (imem_wr),
        .imem_addr  (imem_addr),
        .imem_wdata (imem_wdata),
        .imem_ready (imem_ready)
    );

    // R6: the end of a copy leaves done set
    a_r6_done_at_end: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(eng_busy) |-> regs_q.done);

    // R6: a launch with work to do clears done
    a_r6_clear_on_launch: assert property (@(posedge clk) disable iff (!rst_n)
        launch && regs_q.cnt != '0 |=> !regs_q.done && eng_busy);

    // R7: a zero-length launch completes at once
    a_r7_zero_count: assert property (@(posedge clk) disable iff (!rst_n)
        launch && regs_q.cnt == '0 |=> !eng_busy && regs_q.done);
endmodule

// File: tb/boot_loader_test.sv
module boot_loader_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0, pwr_up = 1'b0, imem_ready = 1'b1;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata, imem_addr, imem_wdata;
    logic        imem_wr;

    int n_chk = 0, n_fail = 0, cyc = 0, cap_n = 0;
    int ready_mode = 0;
    logic [7:0]  lfsr = 8'h5B;
    logic [31:0] cap_addr [64];
    logic [31:0] cap_data [64];
    int          cap_cyc  [64];

    always #4 clk = ~clk;

    boot_loader uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pwr_up(pwr_up), .imem_wr(imem_wr), .imem_addr(imem_addr),
        .imem_wdata(imem_wdata), .imem_ready(imem_ready)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (rst_n && imem_wr && imem_ready && cap_n < 64) begin
            cap_addr[cap_n] <= imem_addr;
            cap_data[cap_n] <= imem_wdata;
            cap_cyc[cap_n]  <= cyc;
            cap_n           <= cap_n + 1;
        end
    end

    always @(negedge clk) begin
        lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        case (ready_mode)
            0: imem_ready = 1'b1;
            1: imem_ready = lfsr[0];
            default: imem_ready = 1'b0;
        endcase
    end

    function automatic logic [31:0] pat(int i);
        return 32'hC0DE0000 ^ (32'(i) * 32'h00010203);
    endfunction

    task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_write(logic [11:0] a, logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic pulse_pwr();
        @(negedge clk);
        pwr_up = 1'b1;
        @(negedge clk);
        pwr_up = 1'b0;
    endtask

    task automatic wait_idle();
        logic [31:0] v;
        for (int k = 0; k < 2000; k++) begin
            bus_read(12'h000, v);
            if (!v[31]) break;
        end
    endtask

    task automatic setup(logic [31:0] src, logic [31:0] dst, logic [31:0] cnt);
        bus_write(12'h004, src);
        bus_write(12'h008, dst);
        bus_write(12'h00C, cnt);
    endtask

    task automatic check_copy(string tag, int n, int first, logic [31:0] dst);
        check(cap_n == n, {tag, " count"}, 32'(cap_n), 32'(n));
        for (int k = 0; k < n && k < cap_n; k++) begin
            check(cap_addr[k] == dst + 32'(4 * k), {tag, " addr"}, cap_addr[k], dst + 32'(4 * k));
            check(cap_data[k] == pat(first + k), {tag, " data"}, cap_data[k], pat(first + k));
        end
    endtask

    task automatic t_reset();
        logic [31:0] v;
        bus_read(12'h000, v); check(v == 0, "R1 ctrl after reset", v, 0);
        bus_read(12'h010, v); check(v == 0, "R1 status after reset", v, 0);
        check(imem_wr == 1'b0 && cap_n == 0, "R1 no write after reset", 32'(imem_wr), 0);
    endtask

    task automatic t_store();
        logic [31:0] v;
        for (int i = 0; i < 16; i++) bus_write(12'h400 + 12'(4 * i), pat(i));
        bus_write(12'h7FC, pat(255));
        bus_read(12'h400, v); check(v == pat(0), "R2 store word 0", v, pat(0));
        bus_read(12'h424, v); check(v == pat(9), "R2 store word 9", v, pat(9));
        bus_read(12'h7FC, v); check(v == pat(255), "R2 store last word", v, pat(255));
    endtask

    task automatic t_basic();
        logic [31:0] v;
        cap_n = 0;
        setup(0, 32'h2000, 8);
        bus_write(12'h000, 32'h8000_0000);
        bus_read(12'h000, v); check(v[31] == 1'b1, "R3 go reads 1 while active", v, 32'h8000_0000);
        wait_idle();
        check_copy("R4 basic copy", 8, 0, 32'h2000);
        for (int k = 1; k < 8; k++)
            check(cap_cyc[k] - cap_cyc[0] == k, "R5 one dword per cycle", 32'(cap_cyc[k] - cap_cyc[0]), 32'(k));
        bus_read(12'h010, v); check(v == 1, "R6 done after copy", v, 1);
        bus_read(12'h000, v); check(v == 0, "R3 go cleared after copy", v, 0);
    endtask

    task automatic t_backpressure();
        cap_n = 0;
        ready_mode = 1;
        setup(32'h10, 32'h3000, 6);
        bus_write(12'h000, 32'h8000_0000);
        wait_idle();
        ready_mode = 0;
        check_copy("R5 stalled copy with offset", 6, 4, 32'h3000);
    endtask

    task automatic t_zero();
        logic [31:0] v;
        cap_n = 0;
        setup(0, 32'h3800, 0);
        bus_write(12'h000, 32'h8000_0000);
        bus_read(12'h000, v); check(v == 0, "R7 zero count not active", v, 0);
        bus_read(12'h010, v); check(v == 1, "R7 zero count done", v, 1);
        check(cap_n == 0, "R7 zero count no writes", 32'(cap_n), 0);
    endtask

    task automatic t_busy_ignore();
        logic [31:0] v;
        cap_n = 0;
        ready_mode = 2;
        setup(0, 32'h4000, 3);
        bus_write(12'h000, 32'h8000_0000);
        bus_write(12'h400, 32'hDEAD_BEEF);
        bus_write(12'h00C, 9);
        bus_write(12'h000, 32'h8000_0000);
        ready_mode = 0;
        wait_idle();
        repeat (4) @(negedge clk);
        check_copy("R9 R8 restart and store write ignored", 3, 0, 32'h4000);
        bus_read(12'h400, v); check(v == pat(0), "R8 store kept during copy", v, pat(0));
    endtask

    task automatic t_power();
        logic [31:0] v;
        cap_n = 0;
        setup(0, 32'h5000, 4);
        bus_write(12'h000, 32'h0);
        pulse_pwr();
        repeat (4) @(negedge clk);
        check(cap_n == 0, "R10 unarmed power-up ignored", 32'(cap_n), 0);
        bus_write(12'h000, 32'h4000_0000);
        ready_mode = 2;
        pulse_pwr();
        bus_read(12'h010, v); check(v == 0, "R6 done cleared at launch", v, 0);
        bus_read(12'h000, v); check(v == 32'hC000_0000, "R10 armed launch active", v, 32'hC000_0000);
        pulse_pwr();
        ready_mode = 0;
        wait_idle();
        repeat (4) @(negedge clk);
        check_copy("R10 armed replay", 4, 0, 32'h5000);
        cap_n = 0;
        pulse_pwr();
        wait_idle();
        check_copy("R10 second replay", 4, 0, 32'h5000);
        for (int i = 0; i < 4; i++) begin
            bus_read(12'h400 + 12'(4 * i), v);
            check(v == pat(i), "R11 store survives power-up", v, pat(i));
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_store();
        t_basic();
        t_backpressure();
        t_zero();
        t_busy_ignore();
        t_power();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule